// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models what a NOR flash device returns on its data pins while an embedded program or erase is running. A start pulse for program or erase begins the operation. From then on, every read strobe returns a status byte instead of array data. Bit 6 of that byte inverts on each read. Bit 2 inverts only on reads that land in a sector chosen for erase. A busy flag stays low until a completion pulse arrives.

The model also covers erase suspend and resume, and a program issued while an erase is suspended. Two more cases apply when the target is protected. A program aimed at a protected sector, or an erase whose chosen sectors are all protected, gives a short busy burst with bit 6 toggling and then falls back to array data. The burst lengths are parameters counted in clock cycles. The memory array itself is not modelled; idle reads pass the `array_data` input through.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `ready` is 1 and `dout` is 0.
- R2: A read strobe while idle loads `dout` with `array_data`, visible the cycle after the strobe.
- R3: A start-program pulse while idle to an unprotected sector drives `ready` low from the next cycle. While programming, each read returns a byte whose bit 6 is the inverse of the previous status read's bit 6 and whose bit 2 is 1; all other bits are 0.
- R4: An `op_done` pulse during program or active erase returns `ready` to 1, and later reads return `array_data`.
- R5: A start-erase pulse while idle, with at least one chosen sector unprotected, drives `ready` low. During the erase, bit 6 inverts on every read at any sector. Bit 2 inverts on each read inside a chosen sector. Reads outside the chosen sectors show bit 2 as 1, and the toggle state of bit 2 is left untouched.
- R6: A `suspend` pulse during active erase sets `ready` to 1. While suspended, reads inside chosen sectors hold bit 6 at the value of the last status read and still invert bit 2. Reads outside the chosen sectors return `array_data`. A `resume` pulse drives `ready` low and bit 6 toggles again.
- R7: A start-program pulse while suspended drives `ready` low and bit 6 toggles on each read. `op_done` then returns the block to the suspended state with `ready` at 1.
- R8: A start-program pulse to a protected sector holds `ready` low for exactly `PROT_PROG_CYC` cycles, with bit 6 toggling, and then returns to idle.
- R9: A start-erase pulse whose chosen sectors are all protected holds `ready` low for exactly `PROT_ERASE_CYC` cycles and then returns to idle.
- R10: Pulses that do not apply in the current state are ignored. This covers `suspend` during a program, start-erase with an empty selection, and start-program during active erase.
- R11: Without a read strobe, `dout` holds its value even when `array_data` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_stb | input | 1 | One-cycle read strobe (from output-enable or chip-enable) |
| rd_sect | input | SECT_IDX_W | Sector index of the read address |
| array_data | input | 8 | Array contents at the read address |
| prog_sect | input | SECT_IDX_W | Sector index of the program target |
| erase_sel | input | 2**SECT_IDX_W | Sectors chosen for erase, sampled at start-erase |
| prot_mask | input | 2**SECT_IDX_W | Protected sectors |
| start_prog | input | 1 | Program command completed (final write pulse) |
| start_erase | input | 1 | Erase command completed (final write pulse) |
| suspend | input | 1 | Erase suspend command |
| resume | input | 1 | Erase resume command |
| op_done | input | 1 | Embedded operation finished |
| dout | output | 8 | Registered read data or status byte |
| ready | output | 1 | 1 = ready, 0 = busy |

## Verification
Reads are made in every state at three kinds of sector: inside the erase selection, outside it, and protected. Comparing bit 6 across consecutive reads separates a running operation from a suspended one. Comparing bit 2 across reads in and out of the selection shows which sectors are being erased. Protected starts are timed cycle by cycle with `ready` to check the burst length. Inapplicable pulses are followed by a read or a `ready` sample, to show that the state did not move.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    localparam int DQ_W      = 8;
    localparam int TOG_A_BIT = 6;
    localparam int TOG_B_BIT = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_SUSP_PROG,
        ST_GUARD
    } op_state_e;

    function automatic logic [DQ_W-1:0] mk_status(input logic a, input logic b);
        logic [DQ_W-1:0] v;
        v = '0;
        v[TOG_A_BIT] = a;
        v[TOG_B_BIT] = b;
        return v;
    endfunction
endpackage

// File: rtl/fsg_sector_lookup.sv
module fsg_sector_lookup #(
    parameter int SECT_IDX_W = 3,
    localparam int NUM_SECT  = 2 ** SECT_IDX_W
) (
    input  logic [SECT_IDX_W-1:0] rd_sect,
    input  logic [SECT_IDX_W-1:0] prog_sect,
    input  logic [NUM_SECT-1:0]   held_sel,
    input  logic [NUM_SECT-1:0]   new_sel,
    input  logic [NUM_SECT-1:0]   prot_mask,
    output logic                  rd_in_sel,
    output logic                  prog_prot,
    output logic                  erase_any,
    output logic                  erase_all_prot
);
    assign rd_in_sel      = held_sel[rd_sect];
    assign prog_prot      = prot_mask[prog_sect];
    assign erase_any      = |new_sel;
    assign erase_all_prot = ~|(new_sel & ~prot_mask);
endmodule

// File: rtl/fsg_guard_timer.sv
module fsg_guard_timer #(
    parameter int MAX_LEN = 64,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.active = 1'b1;
            tmr_d.cnt    = len - CNT_W'(1);
        end else if (tmr_q.active) begin
            if (tmr_q.cnt == '0) tmr_d.active = 1'b0;
            else                 tmr_d.cnt    = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign done = tmr_q.active && (tmr_q.cnt == '0);

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt < CNT_W'(MAX_LEN));

    assert_count_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.active && !load && tmr_q.cnt != '0) |=> (tmr_q.cnt == $past(tmr_q.cnt) - CNT_W'(1)));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int SECT_IDX_W     = 3,
    parameter int PROT_PROG_CYC  = 6,
    parameter int PROT_ERASE_CYC = 20,
    localparam int NUM_SECT      = 2 ** SECT_IDX_W,
    localparam int GUARD_MAX     = (PROT_ERASE_CYC > PROT_PROG_CYC) ? PROT_ERASE_CYC : PROT_PROG_CYC,
    localparam int GUARD_W       = $clog2(GUARD_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_stb,
    input  logic [SECT_IDX_W-1:0] rd_sect,
    input  logic [DQ_W-1:0]       array_data,
    input  logic [SECT_IDX_W-1:0] prog_sect,
    input  logic [NUM_SECT-1:0]   erase_sel,
    input  logic [NUM_SECT-1:0]   prot_mask,
    input  logic                  start_prog,
    input  logic                  start_erase,
    input  logic                  suspend,
    input  logic                  resume,
    input  logic                  op_done,
    output logic [DQ_W-1:0]       dout,
    output logic                  ready
);
    typedef struct packed {
        op_state_e           st;
        logic [NUM_SECT-1:0] sel;
        logic                tog_a;
        logic                tog_b;
        logic [DQ_W-1:0]     dout;
    } regs_t;

    regs_t r_d, r_q;

    logic               rd_in_sel, prog_prot, erase_any, erase_all_prot;
    logic               guard_load, guard_done;
    logic [GUARD_W-1:0] guard_len;

    fsg_sector_lookup #(.SECT_IDX_W(SECT_IDX_W)) u_lookup (
        .rd_sect        (rd_sect),
        .prog_sect      (prog_sect),
        .held_sel       (r_q.sel),
        .new_sel        (erase_sel),
        .prot_mask      (prot_mask),
        .rd_in_sel      (rd_in_sel),
        .prog_prot      (prog_prot),
        .erase_any      (erase_any),
        .erase_all_prot (erase_all_prot)
    );

    fsg_guard_timer #(.MAX_LEN(GUARD_MAX)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (guard_load),
        .len   (guard_len),
        .done  (guard_done)
    );

    always_comb begin
        r_d        = r_q;
        guard_load = 1'b0;
        guard_len  = GUARD_W'(PROT_PROG_CYC);

        // state transitions
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_prog) begin
                    if (prog_prot) begin
                        r_d.st     = ST_GUARD;
                        guard_load = 1'b1;
                    end else begin
                        r_d.st = ST_PROG;
                    end
                end else if (start_erase && erase_any) begin
                    if (erase_all_prot) begin
                        r_d.st     = ST_GUARD;
                        guard_load = 1'b1;
                        guard_len  = GUARD_W'(PROT_ERASE_CYC);
                    end else begin
                        r_d.st  = ST_ERASE;
                        r_d.sel = erase_sel;
                    end
                end
            end
            ST_PROG:      if (op_done) r_d.st = ST_IDLE;
            ST_ERASE: begin
                if (op_done) begin
                    r_d.st  = ST_IDLE;
                    r_d.sel = '0;
                end else if (suspend) begin
                    r_d.st = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (resume)          r_d.st = ST_ERASE;
                else if (start_prog) r_d.st = ST_SUSP_PROG;
            end
            ST_SUSP_PROG: if (op_done)    r_d.st = ST_SUSP;
            ST_GUARD:     if (guard_done) r_d.st = ST_IDLE;
            default:      r_d.st = ST_IDLE;
        endcase

        // read path, decided by the state the read arrives in
        if (rd_stb) begin
            unique case (r_q.st)
                ST_IDLE: r_d.dout = array_data;
                ST_SUSP: begin
                    if (rd_in_sel) begin
                        r_d.tog_b = ~r_q.tog_b;
                        r_d.dout  = mk_status(r_q.tog_a, ~r_q.tog_b);
                    end else begin
                        r_d.dout = array_data;
                    end
                end
                default: begin
                    r_d.tog_a = ~r_q.tog_a;
                    if (rd_in_sel) r_d.tog_b = ~r_q.tog_b;
                    r_d.dout = mk_status(~r_q.tog_a, rd_in_sel ? ~r_q.tog_b : 1'b1);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout  = r_q.dout;
    assign ready = (r_q.st == ST_IDLE) || (r_q.st == ST_SUSP);

    assert_idle_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && rd_stb) |=> (dout == $past(array_data)));

    assert_prog_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && start_prog && !prog_prot) |=> !ready);

    assert_prog_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PROG && rd_stb) |=> (dout[TOG_A_BIT] != $past(r_q.tog_a)));

    assert_susp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SUSP && rd_stb && rd_in_sel) |=> (dout[TOG_A_BIT] == $past(r_q.tog_a)));

    assert_hold_no_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(dout));
endmodule

// File: tb/tb_flash_status_gen.sv
`timescale 1ns/1ps
module tb_flash_status_gen;
    localparam int SW = 3;
    localparam int NS = 8;
    localparam int PP = 6;
    localparam int PE = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_stb = 1'b0;
    logic [SW-1:0] rd_sect = '0;
    logic [7:0]    array_data = 8'h00;
    logic [SW-1:0] prog_sect = '0;
    logic [NS-1:0] erase_sel = '0;
    logic [NS-1:0] prot_mask = 8'h80;
    logic          start_prog = 1'b0, start_erase = 1'b0, suspend = 1'b0, resume = 1'b0, op_done = 1'b0;
    logic [7:0]    dout;
    logic          ready;

    int checks = 0;
    int errors = 0;
    int busy_cyc = 0;
    logic last_a, last_b;

    always #2.5 clk = ~clk;

    flash_status_gen #(.SECT_IDX_W(SW), .PROT_PROG_CYC(PP), .PROT_ERASE_CYC(PE)) dut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_sect(rd_sect), .array_data(array_data),
        .prog_sect(prog_sect), .erase_sel(erase_sel), .prot_mask(prot_mask),
        .start_prog(start_prog), .start_erase(start_erase), .suspend(suspend), .resume(resume),
        .op_done(op_done), .dout(dout), .ready(ready)
    );

    always @(posedge clk) begin
        #1;
        if (!ready) busy_cyc++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [SW-1:0] s, output logic [7:0] v);
        @(negedge clk);
        rd_stb = 1'b1; rd_sect = s;
        @(posedge clk); #1;
        v = dout; rd_stb = 1'b0;
    endtask

    // kind: 0 prog, 1 erase, 2 suspend, 3 resume, 4 done
    task automatic pulse(input int kind);
        @(negedge clk);
        case (kind)
            0: start_prog = 1'b1;
            1: start_erase = 1'b1;
            2: suspend = 1'b1;
            3: resume = 1'b1;
            default: op_done = 1'b1;
        endcase
        @(posedge clk); #1;
        start_prog = 1'b0; start_erase = 1'b0; suspend = 1'b0; resume = 1'b0; op_done = 1'b0;
    endtask

    // status read during a running operation: bit 6 must invert
    task automatic status_rd(input logic [SW-1:0] s, input bit in_sel, input string req);
        logic [7:0] v;
        rd(s, v);
        check(v[6] != last_a, req, v[6], !last_a);
        check(v[2] == (in_sel ? !last_b : 1'b1), req, v[2], in_sel ? !last_b : 1'b1);
        check((v & 8'hBB) == 8'h00, req, v, v & 8'h44);
        last_a = v[6];
        if (in_sel) last_b = v[2];
    endtask

    task automatic t_reset();
        check(ready == 1'b1, "R1", ready, 1);
        check(dout == 8'h00, "R1", dout, 0);
    endtask

    task automatic t_idle();
        logic [7:0] v;
        array_data = 8'hA5;
        rd(3'd1, v);
        check(v == 8'hA5, "R2", v, 8'hA5);
        @(negedge clk); array_data = 8'h3C;
        repeat (3) @(posedge clk);
        #1 check(dout == 8'hA5, "R11", dout, 8'hA5);
    endtask

    task automatic t_program();
        logic [7:0] v;
        prog_sect = 3'd2;
        pulse(0);
        check(ready == 1'b0, "R3", ready, 0);
        rd(3'd5, v); last_a = v[6];
        check(v[2] == 1'b1 && (v & 8'hBB) == 0, "R3", v, {1'b0, v[6], 6'b000100});
        status_rd(3'd0, 1'b0, "R3");
        status_rd(3'd7, 1'b0, "R3");
        pulse(2);
        check(ready == 1'b0, "R10", ready, 0);
        status_rd(3'd1, 1'b0, "R10");
        pulse(4);
        check(ready == 1'b1, "R4", ready, 1);
        array_data = 8'h5A;
        rd(3'd2, v);
        check(v == 8'h5A, "R4", v, 8'h5A);
    endtask

    task automatic t_erase_suspend();
        logic [7:0] v;
        logic held_a;
        erase_sel = 8'b0000_0110;
        pulse(1);
        check(ready == 1'b0, "R5", ready, 0);
        rd(3'd5, v); last_a = v[6];
        check(v[2] == 1'b1, "R5", v[2], 1);
        rd(3'd1, v);
        check(v[6] != last_a, "R5", v[6], !last_a);
        last_a = v[6]; last_b = v[2];
        status_rd(3'd2, 1'b1, "R5");
        status_rd(3'd4, 1'b0, "R5");
        status_rd(3'd1, 1'b1, "R5");
        pulse(0);
        check(ready == 1'b0, "R10", ready, 0);
        status_rd(3'd2, 1'b1, "R10");
        pulse(2);
        check(ready == 1'b1, "R6", ready, 1);
        held_a = last_a;
        for (int i = 0; i < 2; i++) begin
            rd(3'd1, v);
            check(v[6] == held_a, "R6", v[6], held_a);
            check(v[2] == !last_b, "R6", v[2], !last_b);
            last_b = v[2];
        end
        array_data = 8'hC3;
        rd(3'd4, v);
        check(v == 8'hC3, "R6", v, 8'hC3);
        prog_sect = 3'd4;
        pulse(0);
        check(ready == 1'b0, "R7", ready, 0);
        status_rd(3'd4, 1'b0, "R7");
        status_rd(3'd3, 1'b0, "R7");
        pulse(4);
        check(ready == 1'b1, "R7", ready, 1);
        array_data = 8'h96;
        rd(3'd4, v);
        check(v == 8'h96, "R7", v, 8'h96);
        pulse(3);
        check(ready == 1'b0, "R6", ready, 0);
        status_rd(3'd2, 1'b1, "R6");
        pulse(4);
        check(ready == 1'b1, "R4", ready, 1);
        array_data = 8'h11;
        rd(3'd1, v);
        check(v == 8'h11, "R4", v, 8'h11);
    endtask

    task automatic t_guard(input bit is_erase, input int exp_len, input string req);
        logic [7:0] v;
        if (is_erase) erase_sel = 8'h80; else prog_sect = 3'd7;
        @(negedge clk); busy_cyc = 0;
        pulse(is_erase ? 1 : 0);
        rd(3'd0, v); last_a = v[6];
        status_rd(3'd6, 1'b0, req);
        while (!ready) begin @(posedge clk); #1; end
        #2;
        check(busy_cyc == exp_len, req, busy_cyc, exp_len);
        array_data = 8'h77;
        rd(3'd7, v);
        check(v == 8'h77, req, v, 8'h77);
    endtask

    task automatic t_empty_erase();
        logic [7:0] v;
        erase_sel = '0;
        pulse(1);
        check(ready == 1'b1, "R10", ready, 1);
        array_data = 8'h2E;
        rd(3'd3, v);
        check(v == 8'h2E, "R10", v, 8'h2E);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1 rst_n = 1'b1;
                @(posedge clk); #1;
                t_reset();
                t_idle();
                t_program();
                t_erase_suspend();
                t_guard(1'b0, PP, "R8");
                t_guard(1'b1, PE, "R9");
                t_empty_erase();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual 1 expected 0");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule